// File: doc/BRIEF.md
# Seven-Track Tape Character Codec

This block sits between word-wide memory traffic and a seven-track tape channel. On the write path it takes a 20-bit word and emits it as a short burst of tape characters. Each character has six data positions plus one parity position. On the read path it takes characters from the tape channel, checks their parity and rebuilds the 20-bit word.

Two recording modes exist. In binary mode the whole word is recorded as four characters. The last character holds only the two remaining bits, padded with zeros, and parity is odd. In character (BCD) mode only the low eighteen bits are recorded, as three characters, and parity is even. All four data paths use valid/ready handshakes. A sticky flag reports read parity failures until it is cleared.

Word bit 19 is the most significant bit and the first bit sent on tape. A character is 7 bits wide: bit 6 is the parity track and bits 5:0 are the data tracks, with bit 5 holding the earliest word bit.

Top module: `tape7_codec`

## Requirements
- R1: In binary mode (`bcd_mode`=0) every written character has an odd number of ones across its 7 bits.
- R2: In BCD mode (`bcd_mode`=1) every written character has an even number of ones across its 7 bits.
- R3: A binary-mode word is written as four characters whose data bits are, in order: word[19:14], word[13:8], word[7:2], then {word[1:0], 4'b0000}.
- R4: A BCD-mode word is written as three characters whose data bits are, in order: word[17:12], word[11:6], word[5:0]. Word bits 19:18 are not recorded.
- R5: `wr_word_ready` stays low from the accept of a word until its last character has been taken. While `wr_char_valid` is high and `wr_char_ready` is low, the character is held unchanged.
- R6: On read in binary mode, four accepted characters rebuild the word from their data bits in the R3 order. The low four data bits of the fourth character are ignored.
- R7: On read in BCD mode, three accepted characters rebuild word[17:0] in the R4 order, and word[19:18] read as zero.
- R8: A read character whose 7 bits fail the parity of the current mode (odd for binary, even for BCD) sets `perr_flag`. The flag stays set until a cycle with `perr_clear` high and no new failure. Characters with good parity leave the flag unchanged.
- R9: A rebuilt word is held on `rd_word_data` with `rd_word_valid` high until it is accepted. `rd_char_ready` is low during that time.
- R10: After reset `wr_word_ready` and `rd_char_ready` are high, `wr_char_valid` and `rd_word_valid` are low, and `perr_flag` is clear.
- R11: The mode is sampled once per word: on the write side at word accept, and on the read side at the first character. A change of `bcd_mode` in the middle of a word does not alter that word's character count or parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bcd_mode | input | 1 | 1 selects character (BCD) mode, 0 selects binary mode |
| wr_word_valid | input | 1 | Write word offered |
| wr_word_ready | output | 1 | Writer can take a word |
| wr_word_data | input | 20 | Word to be written |
| wr_char_valid | output | 1 | Tape character available |
| wr_char_ready | input | 1 | Tape side takes the character |
| wr_char_data | output | 7 | Character: bit 6 parity, bits 5:0 data |
| rd_char_valid | input | 1 | Character read from tape offered |
| rd_char_ready | output | 1 | Reader can take a character |
| rd_char_data | input | 7 | Read character: bit 6 parity, bits 5:0 data |
| rd_word_valid | output | 1 | Rebuilt word available |
| rd_word_ready | input | 1 | Consumer takes the rebuilt word |
| rd_word_data | output | 20 | Rebuilt word |
| perr_clear | input | 1 | Clears the parity error flag |
| perr_flag | output | 1 | Sticky read parity error |

## Verification
The bench builds the block with its default widths: a 20-bit word, six data tracks and a two-bit unrecorded prefix in BCD mode. These defaults bring both packings within reach: the four-character binary case with its four-bit zero tail, and the three-character BCD case. Each written burst is looped back through the reader so that both directions are compared against words worked out from the packing rules. Directed cases then cover backpressure on both sides, a mode flip inside a word, nonzero padding bits, and a corrupted parity track.

// File: rtl/tape7_pkg.sv
// Package: shared widths and the parity helper for the seven-track codec.
// Assumes a word wider than one character and a BCD payload that is a
// whole number of characters.
package tape7_pkg;
    localparam int WORD_W  = 20;   // memory word width
    localparam int CHAR_W  = 6;    // data tracks per character
    localparam int BCD_SKIP = 2;   // leading word bits not recorded in BCD mode

    // Odd-parity track value for a data field (total ones odd).
    function automatic logic odd_track(input logic [CHAR_W-1:0] d);
        return ~(^d);
    endfunction
endpackage

// File: rtl/tape7_parity.sv
// Module: computes the parity track for one character.
// Assumes odd_sel=1 means the 7-bit character must hold an odd count of ones.
module tape7_parity #(
    parameter int CHAR_W = 6
) (
    input  logic [CHAR_W-1:0] data_i,
    input  logic              odd_sel,
    output logic              par_o
);
    // Parity track: even fill plus an inversion for odd sense.
    always_comb begin
        par_o = (^data_i) ^ odd_sel;
    end
endmodule

// File: rtl/tape7_wr_ser.sv
// Module: splits one word into tape characters, first bits first.
// Assumes the word is only accepted while no character of an earlier word
// is outstanding; the mode is latched together with the word.
module tape7_wr_ser #(
    parameter int WORD_W   = 20,
    parameter int CHAR_W   = 6,
    parameter int BCD_SKIP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcd_mode,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    output logic              char_valid,
    input  logic              char_ready,
    output logic [CHAR_W:0]   char_data
);
    localparam int BIN_CHARS = (WORD_W + CHAR_W - 1) / CHAR_W;
    localparam int BCD_W     = WORD_W - BCD_SKIP;
    localparam int BCD_CHARS = BCD_W / CHAR_W;
    localparam int PAD_W     = BIN_CHARS * CHAR_W;
    localparam int BIN_SHIFT = PAD_W - WORD_W;
    localparam int BCD_SHIFT = PAD_W - BCD_CHARS * CHAR_W;
    localparam int CNT_W     = $clog2(BIN_CHARS + 1);

    logic [PAD_W-1:0] shreg;
    logic [CNT_W-1:0] left;
    logic             bcd_q;
    logic             par_bit;
    logic [PAD_W-1:0] bin_pad;
    logic [PAD_W-1:0] bcd_pad;
    logic             take_word;
    logic             take_char;

    // Handshake decode and left-aligned packing of both modes.
    always_comb begin
        word_ready = (left == '0);
        char_valid = (left != '0);
        take_word  = word_valid && word_ready;
        take_char  = char_valid && char_ready;
        bin_pad    = PAD_W'(word_data) << BIN_SHIFT;
        bcd_pad    = PAD_W'(word_data[BCD_W-1:0]) << BCD_SHIFT;
    end

    // Character shift register, remaining count and latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
            bcd_q <= 1'b0;
        end else if (take_word) begin
            shreg <= bcd_mode ? bcd_pad : bin_pad;
            left  <= bcd_mode ? CNT_W'(BCD_CHARS) : CNT_W'(BIN_CHARS);
            bcd_q <= bcd_mode;
        end else if (take_char) begin
            shreg <= shreg << CHAR_W;
            left  <= left - 1'b1;
        end
    end

    tape7_parity #(.CHAR_W(CHAR_W)) u_par (
        .data_i  (shreg[PAD_W-1 -: CHAR_W]),
        .odd_sel (~bcd_q),
        .par_o   (par_bit)
    );

    // Output character: parity track on top of the data tracks.
    always_comb begin
        char_data = {par_bit, shreg[PAD_W-1 -: CHAR_W]};
    end

    AST_WR_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !bcd_q) |-> (^char_data) == 1'b1); // R1
    AST_WR_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && bcd_q) |-> (^char_data) == 1'b0); // R2
    AST_WR_CHAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !char_ready) |=> (char_valid && $stable(char_data))); // R5
    AST_WR_NO_WORD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take_word |=> !word_ready); // R5
    AST_WR_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !take_word) |=> $stable(bcd_q)); // R11
endmodule

// File: rtl/tape7_rd_deser.sv
// Module: gathers tape characters back into words and checks parity.
// Assumes the mode seen with the first character holds for the whole word;
// a finished word blocks further characters until it is taken.
module tape7_rd_deser #(
    parameter int WORD_W   = 20,
    parameter int CHAR_W   = 6,
    parameter int BCD_SKIP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcd_mode,
    input  logic              char_valid,
    output logic              char_ready,
    input  logic [CHAR_W:0]   char_data,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [WORD_W-1:0] word_data,
    input  logic              perr_clear,
    output logic              perr_flag
);
    localparam int BIN_CHARS = (WORD_W + CHAR_W - 1) / CHAR_W;
    localparam int BCD_W     = WORD_W - BCD_SKIP;
    localparam int BCD_CHARS = BCD_W / CHAR_W;
    localparam int PAD_W     = BIN_CHARS * CHAR_W;
    localparam int BIN_SHIFT = PAD_W - WORD_W;
    localparam int CNT_W     = $clog2(BIN_CHARS + 1);

    logic [PAD_W-1:0] acc;
    logic [PAD_W-1:0] acc_n;
    logic [CNT_W-1:0] got;
    logic             bcd_q;
    logic             mode_now;
    logic             exp_par;
    logic             take_char;
    logic             last_char;
    logic             bad_par;
    logic [WORD_W-1:0] word_n;

    // Decode handshake, effective mode and the word being completed.
    always_comb begin
        char_ready = !word_valid;
        take_char  = char_valid && char_ready;
        mode_now   = (got == '0) ? bcd_mode : bcd_q;
        acc_n      = {acc[PAD_W-CHAR_W-1:0], char_data[CHAR_W-1:0]};
        last_char  = (got + 1'b1) == (mode_now ? CNT_W'(BCD_CHARS) : CNT_W'(BIN_CHARS));
        bad_par    = take_char && (char_data[CHAR_W] != exp_par);
        word_n     = mode_now ? WORD_W'(acc_n[BCD_W-1:0])
                              : WORD_W'(acc_n >> BIN_SHIFT);
    end

    tape7_parity #(.CHAR_W(CHAR_W)) u_par (
        .data_i  (char_data[CHAR_W-1:0]),
        .odd_sel (~mode_now),
        .par_o   (exp_par)
    );

    // Accumulator, character count and mode latched at the first character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            got   <= '0;
            bcd_q <= 1'b0;
        end else if (take_char) begin
            acc   <= acc_n;
            bcd_q <= mode_now;
            got   <= last_char ? '0 : got + 1'b1;
        end
    end

    // Output word register, held until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else if (take_char && last_char) begin
            word_valid <= 1'b1;
            word_data  <= word_n;
        end else if (word_valid && word_ready) begin
            word_valid <= 1'b0;
        end
    end

    // Sticky parity error: a new failure wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_flag <= 1'b0;
        end else if (bad_par) begin
            perr_flag <= 1'b1;
        end else if (perr_clear) begin
            perr_flag <= 1'b0;
        end
    end

    AST_RD_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data))); // R9
    AST_RD_BLOCK_CHARS: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !char_ready); // R9
    AST_RD_BCD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (take_char && last_char && mode_now) |=> (word_data[WORD_W-1 -: BCD_SKIP] == '0)); // R7
    AST_RD_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_flag && !perr_clear) |=> perr_flag); // R8
    AST_RD_PERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bad_par |=> perr_flag); // R8
endmodule

// File: rtl/tape7_codec.sv
// Module: top of the seven-track tape character codec, joining the write
// serializer and the read deserializer under one mode input.
// Assumes both paths share one clock and a synchronous active-low reset.
module tape7_codec #(
    parameter int WORD_W   = tape7_pkg::WORD_W,
    parameter int CHAR_W   = tape7_pkg::CHAR_W,
    parameter int BCD_SKIP = tape7_pkg::BCD_SKIP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcd_mode,
    input  logic              wr_word_valid,
    output logic              wr_word_ready,
    input  logic [WORD_W-1:0] wr_word_data,
    output logic              wr_char_valid,
    input  logic              wr_char_ready,
    output logic [CHAR_W:0]   wr_char_data,
    input  logic              rd_char_valid,
    output logic              rd_char_ready,
    input  logic [CHAR_W:0]   rd_char_data,
    output logic              rd_word_valid,
    input  logic              rd_word_ready,
    output logic [WORD_W-1:0] rd_word_data,
    input  logic              perr_clear,
    output logic              perr_flag
);
    tape7_wr_ser #(.WORD_W(WORD_W), .CHAR_W(CHAR_W), .BCD_SKIP(BCD_SKIP)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bcd_mode   (bcd_mode),
        .word_valid (wr_word_valid),
        .word_ready (wr_word_ready),
        .word_data  (wr_word_data),
        .char_valid (wr_char_valid),
        .char_ready (wr_char_ready),
        .char_data  (wr_char_data)
    );

    tape7_rd_deser #(.WORD_W(WORD_W), .CHAR_W(CHAR_W), .BCD_SKIP(BCD_SKIP)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .bcd_mode   (bcd_mode),
        .char_valid (rd_char_valid),
        .char_ready (rd_char_ready),
        .char_data  (rd_char_data),
        .word_valid (rd_word_valid),
        .word_ready (rd_word_ready),
        .word_data  (rd_word_data),
        .perr_clear (perr_clear),
        .perr_flag  (perr_flag)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (wr_word_ready && !wr_char_valid && rd_char_ready
                    && !rd_word_valid && !perr_flag)); // R10
endmodule

// File: tb/sim_tape7_codec.sv
// Bench: walks a vector table through write then read loopback, then
// runs directed cases for reset, backpressure, mode flips and parity.
module sim_tape7_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bcd_mode = 1'b0;
    logic        wr_word_valid = 1'b0;
    logic        wr_word_ready;
    logic [19:0] wr_word_data = '0;
    logic        wr_char_valid;
    logic        wr_char_ready = 1'b1;
    logic [6:0]  wr_char_data;
    logic        rd_char_valid = 1'b0;
    logic        rd_char_ready;
    logic [6:0]  rd_char_data = '0;
    logic        rd_word_valid;
    logic        rd_word_ready = 1'b1;
    logic [19:0] rd_word_data;
    logic        perr_clear = 1'b0;
    logic        perr_flag;

    int checks = 0;
    int failures = 0;
    logic [6:0] got [0:7];
    int got_n;

    always #4 clk = ~clk;

    tape7_codec u0 (.*);

    // {mode, word}
    localparam logic [20:0] VEC [0:6] = '{
        {1'b0, 20'hFFFFF}, {1'b0, 20'h00000}, {1'b0, 20'hA5C3F},
        {1'b1, 20'hFFFFF}, {1'b1, 20'h3F03F}, {1'b1, 20'h00001},
        {1'b0, 20'h80001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] mkchar(input logic bcd, input logic [5:0] d);
        return {bcd ? ^d : ~(^d), d};
    endfunction

    function automatic logic [6:0] exp_char(input logic bcd, input logic [19:0] w, input int i);
        logic [5:0] d;
        if (bcd) d = (i == 0) ? w[17:12] : (i == 1) ? w[11:6] : w[5:0];
        else     d = (i == 0) ? w[19:14] : (i == 1) ? w[13:8] :
                     (i == 2) ? w[7:2] : {w[1:0], 4'b0000};
        return mkchar(bcd, d);
    endfunction

    // Offer a word at a falling edge; it is taken at the next rising edge.
    task automatic send_word(input logic [19:0] w);
        chk("R5 word ready before send", {31'b0, wr_word_ready}, 32'd1);
        wr_word_data  = w;
        wr_word_valid = 1'b1;
        @(negedge clk);
        wr_word_valid = 1'b0;
    endtask

    // Record characters seen at falling edges while the tape side is ready.
    task automatic collect(input int cycles);
        got_n = 0;
        for (int c = 0; c < cycles; c++) begin
            if (wr_char_valid && wr_char_ready && got_n < 8) begin
                got[got_n] = wr_char_data;
                got_n++;
            end
            @(negedge clk);
        end
    endtask

    task automatic put_char(input logic [6:0] ch);
        chk("R9 char ready when idle", {31'b0, rd_char_ready}, 32'd1);
        rd_char_data  = ch;
        rd_char_valid = 1'b1;
        @(negedge clk);
        rd_char_valid = 1'b0;
    endtask

    initial begin : watchdog
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [19:0] w;
        logic        m;
        logic [19:0] hold;
        logic [6:0]  c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 wr_word_ready", {31'b0, wr_word_ready}, 32'd1);
        chk("R10 wr_char_valid", {31'b0, wr_char_valid}, 32'd0);
        chk("R10 rd_char_ready", {31'b0, rd_char_ready}, 32'd1);
        chk("R10 rd_word_valid", {31'b0, rd_word_valid}, 32'd0);
        chk("R10 perr_flag", {31'b0, perr_flag}, 32'd0);

        // Table walk: write, compare characters, loop back through the reader.
        for (int v = 0; v < 7; v++) begin
            m = VEC[v][20];
            w = VEC[v][19:0];
            bcd_mode = m;
            send_word(w);
            collect(8);
            chk(m ? "R4 char count" : "R3 char count", got_n, m ? 3 : 4);
            for (int i = 0; i < (m ? 3 : 4); i++) begin
                chk(m ? "R2 R4 bcd char" : "R1 R3 bin char", {25'b0, got[i]}, {25'b0, exp_char(m, w, i)});
            end
            for (int i = 0; i < got_n; i++) put_char(got[i]);
            chk("R9 word valid", {31'b0, rd_word_valid}, 32'd1);
            chk(m ? "R7 bcd rebuild" : "R6 bin rebuild", {12'b0, rd_word_data},
                {12'b0, m ? {2'b00, w[17:0]} : w});
            @(negedge clk);
            chk("R8 no error on good parity", {31'b0, perr_flag}, 32'd0);
        end

        // R5 backpressure on the write side.
        bcd_mode = 1'b0;
        wr_char_ready = 1'b0;
        send_word(20'h6B2D1);
        c0 = wr_char_data;
        repeat (3) @(negedge clk);
        chk("R5 held valid", {31'b0, wr_char_valid}, 32'd1);
        chk("R5 held data", {25'b0, wr_char_data}, {25'b0, c0});
        chk("R5 busy", {31'b0, wr_word_ready}, 32'd0);
        wr_char_ready = 1'b1;
        collect(6);
        chk("R5 chars after release", got_n, 4);
        chk("R5 word ready after burst", {31'b0, wr_word_ready}, 32'd1);

        // R11 mode flips after write accept.
        bcd_mode = 1'b0;
        send_word(20'h0F0F0);
        bcd_mode = 1'b1;
        collect(7);
        chk("R11 write count", got_n, 4);
        for (int i = 0; i < 4; i++)
            chk("R11 R1 write odd parity", {31'b0, ^got[i]}, 32'd1);

        // R11 mode flips after first read character.
        bcd_mode = 1'b0;
        put_char(exp_char(1'b0, 20'hC0FFE, 0));
        bcd_mode = 1'b1;
        for (int i = 1; i < 4; i++) put_char(exp_char(1'b0, 20'hC0FFE, i));
        chk("R11 read word", {12'b0, rd_word_data}, {12'b0, 20'hC0FFE});
        chk("R11 read no perr", {31'b0, perr_flag}, 32'd0);
        @(negedge clk);

        // R6 nonzero padding in the fourth binary character is ignored.
        bcd_mode = 1'b0;
        for (int i = 0; i < 3; i++) put_char(exp_char(1'b0, 20'h12345, i));
        put_char(mkchar(1'b0, {2'b01, 4'b1111}));
        chk("R6 padding ignored", {12'b0, rd_word_data}, {12'b0, 20'h12345});
        chk("R6 padding no perr", {31'b0, perr_flag}, 32'd0);
        @(negedge clk);

        // R9 hold the rebuilt word under consumer backpressure.
        bcd_mode = 1'b1;
        rd_word_ready = 1'b0;
        for (int i = 0; i < 3; i++) put_char(exp_char(1'b1, 20'hFABCD, i));
        hold = rd_word_data;
        @(negedge clk);
        chk("R9 still valid", {31'b0, rd_word_valid}, 32'd1);
        chk("R9 data stable", {12'b0, rd_word_data}, {12'b0, hold});
        chk("R7 top bits zero", {12'b0, rd_word_data}, {12'b0, 20'h3ABCD});
        chk("R9 char ready low", {31'b0, rd_char_ready}, 32'd0);
        rd_word_ready = 1'b1;
        @(negedge clk);
        chk("R9 released", {31'b0, rd_word_valid}, 32'd0);

        // R8 bad parity in binary mode sets the sticky flag.
        bcd_mode = 1'b0;
        put_char(exp_char(1'b0, 20'h55555, 0));
        put_char(exp_char(1'b0, 20'h55555, 1) ^ 7'h40);
        chk("R8 flag set", {31'b0, perr_flag}, 32'd1);
        put_char(exp_char(1'b0, 20'h55555, 2));
        put_char(exp_char(1'b0, 20'h55555, 3));
        chk("R8 flag sticky", {31'b0, perr_flag}, 32'd1);
        @(negedge clk);
        perr_clear = 1'b1;
        @(negedge clk);
        perr_clear = 1'b0;
        chk("R8 flag cleared", {31'b0, perr_flag}, 32'd0);

        // R8 odd-parity character is a failure in BCD mode.
        bcd_mode = 1'b1;
        put_char(mkchar(1'b0, 6'h21));
        chk("R8 bcd sense", {31'b0, perr_flag}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule